// File: doc/BRIEF.md
# Composite-Word ECC Memory Wrapper

This block is a synchronous on-chip memory. Its user port takes 32-bit reads and writes at a word address. Inside, the words sit in groups of four. Each group forms one 128-bit composite, and one shared set of error-correcting check bits protects that composite. The code is an extended Hamming code that corrects single errors and detects double errors. It has eight position check bits and one overall parity bit, so each codeword is 137 bits wide. A read decodes the whole composite, corrects a single-bit error and returns the addressed word. It also flags whether a correction was made or the error could not be corrected.

Because the check bits are shared, a write to one word cannot refresh them on its own. In the same cycle, the write reads the composite, corrects the three other words, inserts the new word and re-encodes all four. It then writes the complete composite back. Each physical row holds two composites, lane A and lane B, interleaved column by column. An upset that hits two neighbouring cells therefore becomes one correctable error in each codeword. A fault-modelling input flips chosen physical bits of a row so that this behaviour can be exercised.

Top module: `mecc_sram`

## Requirements
- R1: After reset every word reads as zero, with `corr_o` and `uncorr_o` low.
- R2: A read request returns the word last written at that address on `rdata_o`, with `rvalid_o` high, in the cycle after the request. A write completes in its own request cycle.
- R3: A flip of any single bit of a codeword is corrected on a read: `rdata_o` is the stored word, `corr_o` is 1 and `uncorr_o` is 0. The codeword layout is: bit 32w+b is bit b of word w (w = address bits [1:0]), bits 128..135 are the position check bits, and bit 136 is the overall parity bit.
- R4: Two flipped bits in one codeword give `uncorr_o`=1 and `corr_o`=0 on a read. The two flags are never high together.
- R5: With the default interleaved layout, codeword bit j of lane L (L = address bit 2) is stored at row bit 2j+L. A flip of row bits 2j and 2j+1 together is therefore corrected in both lanes.
- R6: A write to a composite that holds a single error elsewhere reports `corr_o`=1. The write stores the corrected composite, so later reads of every word in it return the right data with no flag.
- R7: A write to a composite with a double error reports `uncorr_o`=1 and still stores the new word. The other words are written back exactly as read, so the composite reads back consistent (no flag) with the corrupted values.
- R8: A write changes neither the other lane of its row nor any other row. An error already present there is still reported on a later read.
- R9: While `flip_en_i` is high, `flip_mask_i` is XORed into row `flip_row_i`. Any request in that cycle is ignored: nothing is stored, and the next cycle shows no `rvalid_o` or flag.
- R10: In the cycle after a cycle with no request, `rvalid_o`, `corr_o` and `uncorr_o` are low. `rdata_o` changes only in cycles where `rvalid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset; clears all storage |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Word address: [1:0] word, [2] lane, [6:3] row |
| wdata_i | input | 32 | Write data |
| flip_en_i | input | 1 | Apply a bit-flip mask to a stored row |
| flip_row_i | input | 4 | Row hit by the flip mask |
| flip_mask_i | input | 274 | Physical row bits to invert |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Corrected read word |
| corr_o | output | 1 | Single error corrected in the accessed composite |
| uncorr_o | output | 1 | Uncorrectable error in the accessed composite |

## Verification
The bench drives each request on a falling edge. The request is registered at the next rising edge. The bench samples `rdata_o`, `rvalid_o` and the two flags at the following falling edge, which is exactly one cycle after the request. A write's flags are sampled at the same point after the write, and the effect on storage is observed through a read issued later. A flip takes effect at the rising edge on which it is presented, so the read that observes it is issued no earlier than the cycle after.

// File: rtl/mecc_pkg.sv
package mecc_pkg;

   // Number of position check bits needed for k data bits.
   function automatic int unsigned ham_width(input int unsigned k);
      int unsigned r;
      r = 1;
      for (int unsigned t = 1; t < 31; t++) begin
         if ((32'd1 << r) < k + r + 1) r = t + 1;
      end
      return r;
   endfunction

   // Codeword position (1-based) of data bit i: positions that are powers
   // of two are skipped, they hold the check bits.
   function automatic int unsigned data_pos(input int unsigned i);
      int unsigned p;
      p = i + 1;
      for (int unsigned r = 0; r < 31; r++) begin
         if ((32'd1 << r) <= p) p = p + 1;
      end
      return p;
   endfunction

endpackage

// File: rtl/mecc_enc.sv
module mecc_enc #(
   parameter int unsigned CMP_W = 128,
   parameter int unsigned HAM_W = mecc_pkg::ham_width(CMP_W)
) (
   input  logic [CMP_W-1:0] data_i,
   output logic [HAM_W-1:0] ham_o,
   output logic             par_o
);

   logic [HAM_W-1:0] term [CMP_W];

   for (genvar i = 0; i < CMP_W; i++) begin : g_term
      localparam int unsigned P = mecc_pkg::data_pos(i);
      assign term[i] = data_i[i] ? HAM_W'(P) : '0;
   end

   always_comb begin
      ham_o = '0;
      for (int i = 0; i < CMP_W; i++) ham_o = ham_o ^ term[i];
   end

   assign par_o = (^data_i) ^ (^ham_o);

endmodule

// File: rtl/mecc_dec.sv
module mecc_dec #(
   parameter int unsigned CMP_W = 128,
   parameter int unsigned HAM_W = mecc_pkg::ham_width(CMP_W)
) (
   input  logic [CMP_W-1:0] data_i,
   input  logic [HAM_W-1:0] ham_i,
   input  logic             par_i,
   output logic [CMP_W-1:0] data_o,
   output logic             single_o,
   output logic             double_o
);

   localparam int unsigned MAX_POS = CMP_W + HAM_W;

   logic [HAM_W-1:0] ham_calc;
   logic             par_calc;
   logic [HAM_W-1:0] syn;
   logic             odd;
   logic             in_range;

   mecc_enc #(.CMP_W(CMP_W), .HAM_W(HAM_W)) u_enc (
      .data_i (data_i),
      .ham_o  (ham_calc),
      .par_o  (par_calc)
   );

   assign syn      = ham_calc ^ ham_i;
   assign odd      = par_calc ^ (^syn) ^ par_i;
   assign in_range = (int'(syn) <= int'(MAX_POS));
   assign single_o = odd && in_range;
   assign double_o = (!odd && (syn != '0)) || (odd && !in_range);

   for (genvar i = 0; i < CMP_W; i++) begin : g_fix
      localparam int unsigned P = mecc_pkg::data_pos(i);
      assign data_o[i] = data_i[i] ^ (single_o && (syn == HAM_W'(P)));
   end

   always_comb begin
      assert_no_fix_without_single_R3: assert (single_o || (data_o == data_i));
      assert_flags_disjoint_R4: assert (!(single_o && double_o));
   end

endmodule

// File: rtl/mecc_lane_map.sv
module mecc_lane_map #(
   parameter int unsigned CW_W       = 137,
   parameter bit          INTERLEAVE = 1'b1
) (
   input  logic [2*CW_W-1:0] row_i,
   output logic [CW_W-1:0]   cw_a_o,
   output logic [CW_W-1:0]   cw_b_o,
   input  logic [CW_W-1:0]   cw_a_i,
   input  logic [CW_W-1:0]   cw_b_i,
   output logic [2*CW_W-1:0] row_o
);

   if (INTERLEAVE) begin : g_column
      for (genvar j = 0; j < CW_W; j++) begin : g_bit
         assign cw_a_o[j]      = row_i[2*j];
         assign cw_b_o[j]      = row_i[2*j+1];
         assign row_o[2*j]     = cw_a_i[j];
         assign row_o[2*j+1]   = cw_b_i[j];
      end
   end else begin : g_block
      assign cw_a_o = row_i[CW_W-1:0];
      assign cw_b_o = row_i[2*CW_W-1:CW_W];
      assign row_o  = {cw_b_i, cw_a_i};
   end

endmodule

// File: rtl/mecc_sram.sv
module mecc_sram #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned GROUP_WORDS = 4,
   parameter int unsigned ROWS        = 16,
   parameter bit          INTERLEAVE  = 1'b1,
   localparam int unsigned CMP_W  = DATA_W * GROUP_WORDS,
   localparam int unsigned HAM_W  = mecc_pkg::ham_width(CMP_W),
   localparam int unsigned CW_W   = CMP_W + HAM_W + 1,
   localparam int unsigned ROW_W  = 2 * CW_W,
   localparam int unsigned WSEL_W = $clog2(GROUP_WORDS),
   localparam int unsigned ROW_AW = $clog2(ROWS),
   localparam int unsigned AW     = ROW_AW + WSEL_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              flip_en_i,
   input  logic [ROW_AW-1:0] flip_row_i,
   input  logic [ROW_W-1:0]  flip_mask_i,
   output logic              rvalid_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              corr_o,
   output logic              uncorr_o
);

   if ((GROUP_WORDS < 2) || ((GROUP_WORDS & (GROUP_WORDS - 1)) != 0)) begin : g_bad_group
      $error("GROUP_WORDS must be a power of two of at least 2");
   end
   if ((ROWS < 2) || ((ROWS & (ROWS - 1)) != 0)) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [ROW_W-1:0]  mem [ROWS];

   logic [ROW_AW-1:0] acc_row;
   logic              acc_lane;
   logic [WSEL_W-1:0] acc_word;
   logic [ROW_W-1:0]  row_rd;
   logic [ROW_W-1:0]  row_wr;
   logic [CW_W-1:0]   cw_a;
   logic [CW_W-1:0]   cw_b;
   logic [CW_W-1:0]   cw_sel;
   logic [CW_W-1:0]   cw_new;
   logic [CW_W-1:0]   new_a;
   logic [CW_W-1:0]   new_b;
   logic [CMP_W-1:0]  fixed;
   logic [CMP_W-1:0]  merged;
   logic [HAM_W-1:0]  new_ham;
   logic              new_par;
   logic              err_single;
   logic              err_double;
   logic              take_req;
   logic              do_read;
   logic              do_write;

   assign acc_row  = addr_i[AW-1 -: ROW_AW];
   assign acc_lane = addr_i[WSEL_W];
   assign acc_word = addr_i[WSEL_W-1:0];
   assign row_rd   = mem[acc_row];

   assign take_req = req_i && !flip_en_i;
   assign do_read  = take_req && !we_i;
   assign do_write = take_req && we_i;

   mecc_lane_map #(.CW_W(CW_W), .INTERLEAVE(INTERLEAVE)) u_lanes (
      .row_i  (row_rd),
      .cw_a_o (cw_a),
      .cw_b_o (cw_b),
      .cw_a_i (new_a),
      .cw_b_i (new_b),
      .row_o  (row_wr)
   );

   assign cw_sel = acc_lane ? cw_b : cw_a;

   mecc_dec #(.CMP_W(CMP_W), .HAM_W(HAM_W)) u_dec (
      .data_i   (cw_sel[CMP_W-1:0]),
      .ham_i    (cw_sel[CMP_W +: HAM_W]),
      .par_i    (cw_sel[CW_W-1]),
      .data_o   (fixed),
      .single_o (err_single),
      .double_o (err_double)
   );

   // Rebuild the composite: corrected neighbours (raw ones when the error
   // is beyond correction) plus the new word, then re-encode all of it.
   always_comb begin
      merged = err_double ? cw_sel[CMP_W-1:0] : fixed;
      merged[acc_word*DATA_W +: DATA_W] = wdata_i;
   end

   mecc_enc #(.CMP_W(CMP_W), .HAM_W(HAM_W)) u_enc (
      .data_i (merged),
      .ham_o  (new_ham),
      .par_o  (new_par)
   );

   assign cw_new = {new_par, new_ham, merged};
   assign new_a  = acc_lane ? cw_a : cw_new;
   assign new_b  = acc_lane ? cw_new : cw_b;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int r = 0; r < int'(ROWS); r++) mem[r] <= '0;
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
         corr_o   <= 1'b0;
         uncorr_o <= 1'b0;
      end else begin
         if (flip_en_i) begin
            mem[flip_row_i] <= mem[flip_row_i] ^ flip_mask_i;
         end else if (do_write) begin
            mem[acc_row] <= row_wr;
         end
         rvalid_o <= do_read;
         corr_o   <= take_req && err_single;
         uncorr_o <= take_req && err_double;
         if (do_read) rdata_o <= fixed[acc_word*DATA_W +: DATA_W];
      end
   end

   assert_flag_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({corr_o, uncorr_o}));

   assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> (!rvalid_o && !corr_o && !uncorr_o));

   assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rvalid_o |-> $stable(rdata_o));

   assert_flip_blocks_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flip_en_i |=> (!rvalid_o && !corr_o && !uncorr_o));

   assert_write_no_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i) |=> !rvalid_o);

endmodule

// File: tb/mecc_sram_tb_top.sv
module mecc_sram_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NR   = 4;
   localparam int AW   = 5;
   localparam int CW   = 137;
   localparam int RW   = 2 * CW;
   localparam int NW   = NR * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic          flip_en = 1'b0;
   logic [1:0]    flip_row = '0;
   logic [RW-1:0] flip_mask = '0;
   logic          rvalid;
   logic [31:0]   rdata;
   logic          corr;
   logic          uncorr;

   int errors = 0;
   int checks = 0;
   logic [31:0] model [NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   mecc_sram #(.ROWS(NR)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .we_i        (we),
      .addr_i      (addr),
      .wdata_i     (wdata),
      .flip_en_i   (flip_en),
      .flip_row_i  (flip_row),
      .flip_mask_i (flip_mask),
      .rvalid_o    (rvalid),
      .rdata_o     (rdata),
      .corr_o      (corr),
      .uncorr_o    (uncorr)
   );

   function automatic int addr_of(input int row, input int lane, input int w);
      return row * 8 + lane * 4 + w;
   endfunction

   function automatic logic [RW-1:0] bit_of(input int lane, input int j);
      logic [RW-1:0] m;
      m = '0;
      m[2*j+lane] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] pattern(input int a, input int pass);
      return (32'h9E3779B9 * (a + 1)) ^ (pass * 32'h5A5A0F0F);
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // {rvalid, uncorr, corr, data} one cycle after a read request
   task automatic rd_chk(input string tag, input int a, input logic [31:0] ed,
                         input logic ec, input logic eu);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a[AW-1:0];
      @(negedge clk);
      req = 1'b0;
      chk(tag, {29'd0, rvalid, uncorr, corr, rdata}, {29'd0, 1'b1, eu, ec, ed});
   endtask

   task automatic wr(input int a, input logic [31:0] d, output logic c, output logic u);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a[AW-1:0]; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      c = corr; u = uncorr;
      model[a] = d;
   endtask

   task automatic flip(input int row, input logic [RW-1:0] m);
      @(negedge clk);
      flip_en = 1'b1; flip_row = row[1:0]; flip_mask = m;
      @(negedge clk);
      flip_en = 1'b0; flip_mask = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic c, u;
      logic [31:0] hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents
      chk("R1 outputs after reset", {61'd0, rvalid, corr, uncorr}, 64'd0);
      for (int a = 0; a < NW; a++) rd_chk("R1 zero after reset", a, 32'd0, 1'b0, 1'b0);

      // R2: write every word, two passes of patterns
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < NW; a++) begin
            wr(a, pattern(a, p), c, u);
            chk("R2 clean write flags", {62'd0, c, u}, 64'd0);
         end
         for (int a = 0; a < NW; a++) rd_chk("R2 readback", a, model[a], 1'b0, 1'b0);
      end
      wr(5, 32'hFFFFFFFF, c, u);
      wr(6, 32'h00000000, c, u);
      rd_chk("R2 all ones", 5, 32'hFFFFFFFF, 1'b0, 1'b0);
      rd_chk("R2 all zeros", 6, 32'h00000000, 1'b0, 1'b0);

      // R10: idle cycle after a read
      rd_chk("R10 read before idle", 9, model[9], 1'b0, 1'b0);
      hold = model[9];
      @(negedge clk);
      chk("R10 idle quiet", {29'd0, rvalid, corr, uncorr, rdata}, {32'd0, hold});
      wr(10, 32'h12345678, c, u);
      chk("R10 rdata held over write", {31'd0, rvalid, rdata}, {32'd0, hold});

      // R3: every single-bit position in both lanes of row 0
      for (int lane = 0; lane < 2; lane++) begin
         for (int j = 0; j < CW; j++) begin
            int w;
            w = (j < 128) ? (j / 32) : 1;
            flip(0, bit_of(lane, j));
            rd_chk($sformatf("R3 single lane %0d bit %0d", lane, j),
                   addr_of(0, lane, w), model[addr_of(0, lane, w)], 1'b1, 1'b0);
            flip(0, bit_of(lane, j));
         end
      end

      // R5: adjacent physical pairs, each lane corrected
      for (int j = 0; j < CW; j += 3) begin
         int w;
         w = (j < 128) ? (j / 32) : 2;
         flip(1, bit_of(0, j) | bit_of(1, j));
         rd_chk($sformatf("R5 pair lane A bit %0d", j), addr_of(1, 0, w),
                model[addr_of(1, 0, w)], 1'b1, 1'b0);
         rd_chk($sformatf("R5 pair lane B bit %0d", j), addr_of(1, 1, w),
                model[addr_of(1, 1, w)], 1'b1, 1'b0);
         flip(1, bit_of(0, j) | bit_of(1, j));
      end

      // R4: double errors in one codeword
      flip(2, bit_of(0, 10) | bit_of(0, 130));
      rd_chk("R4 data plus check", addr_of(2, 0, 0), model[addr_of(2, 0, 0)] ^ 32'h400, 1'b0, 1'b1);
      flip(2, bit_of(0, 10) | bit_of(0, 130));
      flip(2, bit_of(1, 40) | bit_of(1, 100));
      rd_chk("R4 two data words", addr_of(2, 1, 3), model[addr_of(2, 1, 3)] ^ 32'h10, 1'b0, 1'b1);
      flip(2, bit_of(1, 40) | bit_of(1, 100));
      rd_chk("R4 restored", addr_of(2, 1, 3), model[addr_of(2, 1, 3)], 1'b0, 1'b0);

      // R6: write beside a single error rewrites corrected composite
      flip(1, bit_of(0, 69));
      wr(addr_of(1, 0, 0), 32'hCAFEF00D, c, u);
      chk("R6 write flags corrected", {62'd0, c, u}, {62'd0, 2'b10});
      rd_chk("R6 neighbour clean", addr_of(1, 0, 2), model[addr_of(1, 0, 2)], 1'b0, 1'b0);
      rd_chk("R6 new word", addr_of(1, 0, 0), 32'hCAFEF00D, 1'b0, 1'b0);

      // R7: write beside a double error
      flip(2, bit_of(1, 35) | bit_of(1, 41));
      wr(addr_of(2, 1, 3), 32'h0BADBEEF, c, u);
      chk("R7 write flags uncorrectable", {62'd0, c, u}, {62'd0, 2'b01});
      model[addr_of(2, 1, 1)] = model[addr_of(2, 1, 1)] ^ 32'h00000208;
      rd_chk("R7 corrupted neighbour consistent", addr_of(2, 1, 1), model[addr_of(2, 1, 1)], 1'b0, 1'b0);
      rd_chk("R7 new word stored", addr_of(2, 1, 3), 32'h0BADBEEF, 1'b0, 1'b0);

      // R8: other lane and other rows untouched by a write
      flip(3, bit_of(1, 7));
      wr(addr_of(3, 0, 2), 32'h76543210, c, u);
      rd_chk("R8 other lane error kept", addr_of(3, 1, 0), model[addr_of(3, 1, 0)], 1'b1, 1'b0);
      rd_chk("R8 written lane", addr_of(3, 0, 2), 32'h76543210, 1'b0, 1'b0);
      rd_chk("R8 other row", addr_of(0, 0, 2), model[addr_of(0, 0, 2)], 1'b0, 1'b0);
      flip(3, bit_of(1, 7));

      // R9: request in a flip cycle is ignored
      hold = model[addr_of(0, 1, 1)];
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 5'(addr_of(0, 1, 1)); wdata = 32'hDEADDEAD;
      flip_en = 1'b1; flip_row = 2'd0; flip_mask = bit_of(1, 33);
      @(negedge clk);
      req = 1'b0; we = 1'b0; flip_en = 1'b0; flip_mask = '0;
      chk("R9 ignored request quiet", {61'd0, rvalid, corr, uncorr}, 64'd0);
      rd_chk("R9 write dropped, flip applied", addr_of(0, 1, 1), hold, 1'b1, 1'b0);
      flip(0, bit_of(1, 33));
      rd_chk("R9 restored", addr_of(0, 1, 1), hold, 1'b0, 1'b0);

      report();
      $finish;
   end

endmodule